// File: doc/BRIEF.md
# Three-Product Complex Multiplier

This block multiplies two complex numbers held in 10-bit signed fixed point, using three real products instead of four. One of the three products is shared by the real and imaginary outputs. It serves two jobs in a spectral correlator. The first is rotating a data point by a twiddle factor. The second is forming the product of one spectrum with the complex conjugate of another. A per-sample control input selects between the plain product and the conjugate product.

Let the first operand be x = a + jb and the second be y = c + jd. The block applies the conjugate, when selected, by negating d before the pre-adders. It then forms the three sums c+d, a+b and a-b, and the three products a(c+d), d(a+b) and c(a-b). The real output is a(c+d) - d(a+b). The imaginary output is a(c+d) - c(a-b). The products are kept at full precision. The 8 low fraction bits are then dropped, and the result is clamped to the 10-bit range. The pipeline accepts a new operand pair on every clock. Each result appears a fixed three cycles after its operands.

Top module: `cplx_mul3`

## Requirements
- R1: The number format is 10-bit two's complement, with bit 9 as the sign, bit 8 as the units bit and bits 7..0 as the fraction (value = integer / 256). With d' = d, or d' = -d in conjugate mode, the real output equals floor((a*c - b*d') / 256), then clamped as in R4.
- R2: The imaginary output equals floor((a*d' + b*c) / 256), then clamped as in R4.
- R3: When conjEn is 1 at the sampling edge, the second operand is conjugated (d' = -d). This includes d = -512, which gives d' = +512 without wrapping. When conjEn is 0, d' = d.
- R4: A result above +511 (0x1FF) is output as 0x1FF. A result below -512 is output as 0x200.
- R5: Bits are dropped by truncation toward minus infinity, not by rounding. For example, an exact value of -1/65536 gives -1 (0x3FF).
- R6: outValid rises exactly 3 clock edges after the edge that samples inValid high. It carries the result of that operand pair.
- R7: A new operand pair can be accepted on every clock. Back-to-back pairs, including a mix of conjugate and plain pairs, produce results in order with no gaps.
- R8: A clock with inValid low produces no outValid 3 edges later. While outValid is low, outRe and outIm keep the last result.
- R9: After reset (rstN low), outValid, outRe and outIm are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operand pair is present this cycle |
| conjEn | input | 1 | Conjugate the second operand |
| xRe | input | 10 | First operand, real part (a) |
| xIm | input | 10 | First operand, imaginary part (b) |
| yRe | input | 10 | Second operand, real part (c) |
| yIm | input | 10 | Second operand, imaginary part (d) |
| outValid | output | 1 | Result is valid |
| outRe | output | 10 | Result, real part |
| outIm | output | 10 | Result, imaginary part |

## Verification
Saturation and conjugation can act on the same sample. The worst case is conjEn with d = -512. The negation then yields +512, which feeds a pre-adder that must not wrap and a product that overflows the output range. The bench drives this pair together with full-scale values of a, b and c. It compares both outputs against an integer model that applies the negation, the floor division and the clamp in that order. A long back-to-back random stream also mixes both modes with clamping in consecutive cycles.

// File: rtl/cmul_pkg.sv
package cmul_pkg;
  // Per-stage load strobes sent from the control to the datapath
  typedef struct packed {
    logic s1En;
    logic s2En;
    logic s3En;
  } stageStrobes_t;
endpackage

// File: rtl/cmul_ctrl.sv
module cmul_ctrl
  import cmul_pkg::*;
#(
  parameter int STAGES = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  output stageStrobes_t strobes,
  output logic          outValid
);
  logic [STAGES-1:0] vPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vPipe <= '0;
    else       vPipe <= {vPipe[STAGES-2:0], inValid};
  end

  assign strobes.s1En = inValid;
  assign strobes.s2En = vPipe[0];
  assign strobes.s3En = vPipe[1];
  assign outValid     = vPipe[STAGES-1];

  // R6: every accepted pair yields a result three edges later
  p_latency_r6: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##3 outValid);
  // R8: an idle cycle yields no result
  p_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> ##3 !outValid);
endmodule

// File: rtl/cmul_datapath.sv
module cmul_datapath
  import cmul_pkg::*;
#(
  parameter int W    = 10,
  parameter int FRAC = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  stageStrobes_t       strobes,
  input  logic                conjEn,
  input  logic signed [W-1:0] xRe,
  input  logic signed [W-1:0] xIm,
  input  logic signed [W-1:0] yRe,
  input  logic signed [W-1:0] yIm,
  output logic signed [W-1:0] outRe,
  output logic signed [W-1:0] outIm
);
  localparam int OW = W + 2;      // pre-adder width
  localparam int PW = 2 * OW;     // product width
  localparam int SW = PW + 1;     // post-subtractor width
  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  // ---------- stage 1: conjugate and pre-adders ----------
  logic signed [OW-1:0] extA, extB, extC, extD, dEff;
  assign extA = {{2{xRe[W-1]}}, xRe};
  assign extB = {{2{xIm[W-1]}}, xIm};
  assign extC = {{2{yRe[W-1]}}, yRe};
  assign extD = {{2{yIm[W-1]}}, yIm};
  assign dEff = conjEn ? -extD : extD;

  logic signed [OW-1:0] regA, regC, regD, regCpd, regApb, regAmb;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regA <= '0; regC <= '0; regD <= '0;
      regCpd <= '0; regApb <= '0; regAmb <= '0;
    end else if (strobes.s1En) begin
      regA   <= extA;
      regC   <= extC;
      regD   <= dEff;
      regCpd <= extC + dEff;
      regApb <= extA + extB;
      regAmb <= extA - extB;
    end
  end

  // ---------- stage 2: three products ----------
  function automatic logic signed [PW-1:0] wide(input logic signed [OW-1:0] v);
    return {{(PW-OW){v[OW-1]}}, v};
  endfunction

  logic signed [PW-1:0] pShared, pD, pC;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pShared <= '0; pD <= '0; pC <= '0;
    end else if (strobes.s2En) begin
      pShared <= wide(regA) * wide(regCpd);
      pD      <= wide(regD) * wide(regApb);
      pC      <= wide(regC) * wide(regAmb);
    end
  end

  // ---------- stage 3: post-subtractors, truncation, clamp ----------
  logic signed [SW-1:0] sumRe, sumIm, truncRe, truncIm;
  assign sumRe   = {pShared[PW-1], pShared} - {pD[PW-1], pD};
  assign sumIm   = {pShared[PW-1], pShared} - {pC[PW-1], pC};
  assign truncRe = sumRe >>> FRAC;
  assign truncIm = sumIm >>> FRAC;

  function automatic logic fits(input logic signed [SW-1:0] v);
    return v[SW-1:W-1] == {(SW-W+1){v[SW-1]}};
  endfunction

  function automatic logic signed [W-1:0] clampW(input logic signed [SW-1:0] v);
    if (fits(v))        return v[W-1:0];
    else if (v[SW-1])   return MINV;
    else                return MAXV;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outRe <= '0; outIm <= '0;
    end else if (strobes.s3En) begin
      outRe <= clampW(truncRe);
      outIm <= clampW(truncIm);
    end
  end

  // R3: conjugate mode loads the negated imaginary part of y
  p_conj_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.s1En && conjEn) |=> (regD == -$past(extD)));
  // R4: positive overflow clamps to the top code
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.s3En && !fits(truncRe) && !truncRe[SW-1]) |=> (outRe == MAXV));
  // R4: negative overflow clamps to the bottom code
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.s3En && !fits(truncIm) && truncIm[SW-1]) |=> (outIm == MINV));
  // R8: outputs hold when no result is being loaded
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.s3En |=> ($stable(outRe) && $stable(outIm)));
endmodule

// File: rtl/cplx_mul3.sv
module cplx_mul3
  import cmul_pkg::*;
#(
  parameter int W    = 10,
  parameter int FRAC = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic                conjEn,
  input  logic signed [W-1:0] xRe,
  input  logic signed [W-1:0] xIm,
  input  logic signed [W-1:0] yRe,
  input  logic signed [W-1:0] yIm,
  output logic                outValid,
  output logic signed [W-1:0] outRe,
  output logic signed [W-1:0] outIm
);
  stageStrobes_t strobes;

  cmul_ctrl #(.STAGES(3)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .strobes(strobes), .outValid(outValid)
  );

  cmul_datapath #(.W(W), .FRAC(FRAC)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .conjEn(conjEn),
    .xRe(xRe), .xIm(xIm), .yRe(yRe), .yIm(yIm),
    .outRe(outRe), .outIm(outIm)
  );
endmodule

// File: tb/tb_cplx_mul3.sv
module tb_cplx_mul3;
  localparam int W = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, conjEn = 1'b0;
  logic signed [W-1:0] xRe = '0, xIm = '0, yRe = '0, yIm = '0;
  logic outValid;
  logic signed [W-1:0] outRe, outIm;

  always #5 clk = ~clk;

  cplx_mul3 dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .conjEn(conjEn),
    .xRe(xRe), .xIm(xIm), .yRe(yRe), .yIm(yIm),
    .outValid(outValid), .outRe(outRe), .outIm(outIm)
  );

  int total = 0, bad = 0, cycle = 0;
  int expRe[$], expIm[$], expCyc[$];
  string expTag[$];
  int lastRe = 0, lastIm = 0;
  logic seenOut = 1'b0;
  logic done = 1'b0;

  always @(posedge clk) cycle <= cycle + 1;

  function automatic int clampRef(input int v);
    if (v > 511) return 511;
    if (v < -512) return -512;
    return v;
  endfunction

  // Reference model, R1 R2 R3 R5 R4
  task automatic send(input int a, input int b, input int c, input int d,
                      input logic cj, input string tag);
    int dd, re, im;
    dd = cj ? -d : d;
    re = clampRef((a * c - b * dd) >>> 8);
    im = clampRef((a * dd + b * c) >>> 8);
    @(negedge clk);
    inValid = 1'b1; conjEn = cj;
    xRe = W'(a); xIm = W'(b); yRe = W'(c); yIm = W'(d);
    expRe.push_back(re); expIm.push_back(im);
    expCyc.push_back(cycle + 3); expTag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      xRe = W'(i * 37); yIm = W'(-i);
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (outValid) begin
        if (expRe.size() == 0) begin
          total++; bad++;
          $display("FAIL R8: unexpected outValid, actual=1 expected=0");
        end else begin
          int eRe, eIm, eCyc;
          string t;
          eRe = expRe.pop_front(); eIm = expIm.pop_front();
          eCyc = expCyc.pop_front(); t = expTag.pop_front();
          total++;
          if (cycle != eCyc) begin
            bad++;
            $display("FAIL R6 (%s): result at cycle %0d expected %0d", t, cycle, eCyc);
          end
          total++;
          if (int'(outRe) != eRe || int'(outIm) != eIm) begin
            bad++;
            $display("FAIL %s: actual=(%0d,%0d) expected=(%0d,%0d)",
                     t, outRe, outIm, eRe, eIm);
          end
          lastRe = int'(outRe); lastIm = int'(outIm); seenOut = 1'b1;
        end
      end else if (seenOut) begin
        total++;
        if (int'(outRe) != lastRe || int'(outIm) != lastIm) begin
          bad++;
          $display("FAIL R8 hold: actual=(%0d,%0d) expected=(%0d,%0d)",
                   outRe, outIm, lastRe, lastIm);
        end
      end
    end
  end

  initial begin
    int seed;
    seed = 12345;
    repeat (3) @(negedge clk);
    // R9: reset state
    total++;
    if (outValid !== 1'b0 || outRe !== '0 || outIm !== '0) begin
      bad++;
      $display("FAIL R9: actual=(%b,%0d,%0d) expected=(0,0,0)", outValid, outRe, outIm);
    end
    rstN = 1'b1;
    idle(2);
    send(256, 0, 256, 0, 1'b0, "R1 one*one");
    idle(4);
    send(128, 64, -96, 200, 1'b0, "R1 R2 plain");
    idle(1);
    send(128, 64, -96, 200, 1'b1, "R3 conj");
    send(-1, 0, 1, 0, 1'b0, "R5 floor neg");
    send(1, 0, 1, 0, 1'b0, "R5 floor pos");
    send(-512, 0, -512, 0, 1'b0, "R4 pos clamp");
    send(-512, 511, 511, 511, 1'b0, "R4 neg clamp");
    send(511, 511, 511, -512, 1'b1, "R3 R4 conj of -512");
    send(-512, -512, -512, -512, 1'b1, "R3 R4 all min conj");
    idle(5);
    // R7: back-to-back random stream mixing modes
    for (int k = 0; k < 300; k++) begin
      int r1, r2, r3, r4;
      seed = seed * 1103515245 + 12345; r1 = (seed >>> 8) % 1024 - 512;
      seed = seed * 1103515245 + 12345; r2 = (seed >>> 8) % 1024 - 512;
      seed = seed * 1103515245 + 12345; r3 = (seed >>> 8) % 1024 - 512;
      seed = seed * 1103515245 + 12345; r4 = (seed >>> 8) % 1024 - 512;
      if (r1 < -512) r1 += 1024;
      if (r2 < -512) r2 += 1024;
      if (r3 < -512) r3 += 1024;
      if (r4 < -512) r4 += 1024;
      send(r1, r2, r3, r4, logic'(seed[12]), "R7 stream");
      if (k % 50 == 49) idle(2);
    end
    idle(8);
    // all expected results must have drained (R6/R7)
    total++;
    if (expRe.size() != 0) begin
      bad++;
      $display("FAIL R7: %0d results missing, expected 0", expRe.size());
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule